// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block drives a processor reset from two independent sources. The first is a digital flag from an external comparator that signals the monitored supply is below its threshold. The second is a watchdog that expects activity on a kick input. While the supply is low, reset is held. Once the supply recovers, reset is held for a fixed number of clock cycles and then released. If the watchdog counter runs out, the block produces a reset pulse of the same fixed length and then starts counting again.

The watchdog treats a rising edge and a falling edge on the kick input alike: either one clears the counter. A change of the mode-select level also clears it. The mode level chooses between a base timeout and a timeout 500 times longer. In the long mode, when the kick line is reported floating, the block services itself before the timeout, so no watchdog reset occurs. A static disable strap turns the watchdog off completely. The reset hold time and the base timeout are parameters counted in clock cycles. A parameter also selects the output polarity.

Top module: `rst_supervisor`

## Requirements
- R1: While the synchronized supply-low flag is 1, reset is asserted. It becomes asserted no later than three clock edges after `vlow` rises.
- R2: After the synchronized supply-low flag returns to 0, reset stays asserted for exactly HOLD_CYCLES further cycles and then releases.
- R3: When the watchdog expires, reset is asserted for exactly HOLD_CYCLES cycles.
- R4: The watchdog counter is held at zero while reset is asserted. It restarts from zero on release, so with no activity the released interval lasts exactly the timeout in cycles.
- R5: A rising or a falling edge of the synchronized `kick` clears the watchdog counter and restarts it.
- R6: A change of the synchronized `ext_mode` level, in either direction, clears the watchdog counter.
- R7: With `ext_mode` at 0 the timeout is BASE_CYCLES cycles. With `ext_mode` at 1 it is BASE_CYCLES*EXT_FACTOR cycles (500x by default).
- R8: With no kick activity, the sequence of expiry, reset pulse and restart repeats indefinitely with period HOLD_CYCLES plus the timeout.
- R9: With `ext_mode` at 1 and `kick_float` at 1, the counter clears itself when it reaches SVC_PERCENT percent (94) of the long timeout, so no watchdog reset occurs. With `ext_mode` at 0, `kick_float` has no effect on expiry.
- R10: With `wd_off` at 1, the watchdog never causes a reset, and reset follows only the supply-low path. `wd_active` is 1 exactly when `wd_off` is 0 and the synchronized `ext_mode` and `kick_float` are not both 1.
- R11: `vlow`, `kick`, `ext_mode` and `kick_float` pass through two-flop synchronizers before use. While `rst_n` is low, reset is asserted and the supply-low synchronizer is preset to "low".
- R12: ACTIVE_HIGH=0 gives an active-low `sys_rst` (0 means reset). ACTIVE_HIGH=1 gives the exact inverse waveform. Timing is identical for both settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low initialization of the block |
| vlow | input | 1 | Comparator flag, 1 when the monitored voltage is below threshold |
| kick | input | 1 | Watchdog service input; either edge services |
| kick_float | input | 1 | 1 when the kick line is undriven |
| ext_mode | input | 1 | 0 selects the base timeout, 1 the extended timeout |
| wd_off | input | 1 | Static strap; 1 disables the watchdog |
| sys_rst | output | 1 | Processor reset, polarity set by ACTIVE_HIGH |
| wd_active | output | 1 | 1 while the watchdog can cause a reset |

## Verification
The hardest situation to reach is an expiry in extended mode, and its suppression when the kick line floats. Each needs a quiet stretch tens of thousands of cycles long, with the mode level held steady so that no mode change clears the count. The stimulus reaches it with two long directed stretches: one in extended mode with the kick line driven, and one with it floating. A third directed stretch floats the kick line in normal mode. The bench also flips the mode level in the middle of a normal-mode count, to show that the clear postpones the expiry. A seeded random phase then mixes kick edges, short supply dips and rare mode, float and strap changes. A cycle-level expected model checks every cycle on both polarity variants.

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int HOLD_CYCLES = 16,
  parameter int BASE_CYCLES = 40,
  parameter int EXT_FACTOR  = 500,
  parameter int SVC_PERCENT = 94,
  parameter bit ACTIVE_HIGH = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vlow,
  input  logic kick,
  input  logic kick_float,
  input  logic ext_mode,
  input  logic wd_off,
  output logic sys_rst,
  output logic wd_active
);
  localparam int LONG_CYCLES = BASE_CYCLES * EXT_FACTOR;
  localparam int CW = $clog2(LONG_CYCLES + 1);
  localparam int HW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LIM_N = CW'(BASE_CYCLES - 1);
  localparam logic [CW-1:0] LIM_E = CW'(LONG_CYCLES - 1);
  localparam logic [CW-1:0] SVC_E = CW'((LONG_CYCLES * SVC_PERCENT) / 100);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYCLES - 1);

  logic [1:0] vs_q, ks_q, ms_q, fs_q;
  logic kick_d, mode_d;
  logic rst_act;
  logic [HW-1:0] hold_cnt;
  logic [CW-1:0] wd_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q   <= 2'b11;
      ks_q   <= 2'b00;
      ms_q   <= 2'b00;
      fs_q   <= 2'b00;
      kick_d <= 1'b0;
      mode_d <= 1'b0;
    end else begin
      vs_q   <= {vs_q[0], vlow};
      ks_q   <= {ks_q[0], kick};
      ms_q   <= {ms_q[0], ext_mode};
      fs_q   <= {fs_q[0], kick_float};
      kick_d <= ks_q[1];
      mode_d <= ms_q[1];
    end
  end

  wire v_s = vs_q[1];
  wire m_s = ms_q[1];
  wire f_s = fs_q[1];
  wire kick_edge = ks_q[1] ^ kick_d;
  wire mode_edge = m_s ^ mode_d;
  wire [CW-1:0] lim = m_s ? LIM_E : LIM_N;
  wire self_svc = m_s && f_s && (wd_cnt == SVC_E);
  wire wd_clear = kick_edge || mode_edge || self_svc;
  wire wd_expire = !rst_act && !wd_off && !wd_clear && (wd_cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_act  <= 1'b1;
      hold_cnt <= '0;
    end else if (v_s) begin
      rst_act  <= 1'b1;
      hold_cnt <= '0;
    end else if (rst_act) begin
      if (hold_cnt == HOLD_LAST) begin
        rst_act  <= 1'b0;
        hold_cnt <= '0;
      end else begin
        hold_cnt <= hold_cnt + 1'b1;
      end
    end else if (wd_expire) begin
      rst_act  <= 1'b1;
      hold_cnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               wd_cnt <= '0;
    else if (rst_act || wd_off || wd_clear)   wd_cnt <= '0;
    else if (wd_cnt == lim)                   wd_cnt <= '0;
    else                                      wd_cnt <= wd_cnt + 1'b1;
  end

  assign sys_rst   = ACTIVE_HIGH ? rst_act : !rst_act;
  assign wd_active = !wd_off && !(m_s && f_s);

  AST_LOW_FORCES_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    v_s |=> rst_act); // R1
  AST_HOLD_NOT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_act && !v_s && hold_cnt != HOLD_LAST) |=> rst_act); // R2
  AST_HOLD_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_act && !v_s && hold_cnt == HOLD_LAST) |=> !rst_act); // R3
  AST_CNT_CLEAR_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    rst_act |=> wd_cnt == '0); // R4
  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_edge && !rst_act) |=> (wd_cnt == '0 && !rst_act) || v_s); // R5
  AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_edge |=> wd_cnt == '0); // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_edge |-> wd_cnt <= lim); // R7
  AST_FLOAT_NO_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_s && f_s) |-> !wd_expire); // R9
  AST_OFF_NO_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    wd_off |-> !wd_expire); // R10
endmodule

// File: tb/test_rst_supervisor.sv
module test_rst_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 16;
  localparam int BASE = 40;
  localparam int MULT = 500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vlow = 1'b0, kick = 1'b0, kick_float = 1'b0, ext_mode = 1'b0, wd_off = 1'b0;
  logic rst_lo, act_lo, rst_hi, act_hi;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_supervisor #(.HOLD_CYCLES(HOLD), .BASE_CYCLES(BASE), .EXT_FACTOR(MULT),
                   .SVC_PERCENT(94), .ACTIVE_HIGH(1'b0)) i_rst_supervisor (
    .clk(clk), .rst_n(rst_n), .vlow(vlow), .kick(kick), .kick_float(kick_float),
    .ext_mode(ext_mode), .wd_off(wd_off), .sys_rst(rst_lo), .wd_active(act_lo));

  rst_supervisor #(.HOLD_CYCLES(HOLD), .BASE_CYCLES(BASE), .EXT_FACTOR(MULT),
                   .SVC_PERCENT(94), .ACTIVE_HIGH(1'b1)) i_rst_supervisor_hi (
    .clk(clk), .rst_n(rst_n), .vlow(vlow), .kick(kick), .kick_float(kick_float),
    .ext_mode(ext_mode), .wd_off(wd_off), .sys_rst(rst_hi), .wd_active(act_hi));

  function automatic int lim_of(input bit ext);
    return ext ? BASE * MULT : BASE;
  endfunction
  function automatic int svc_of();
    return (BASE * MULT * 94) / 100;
  endfunction

  logic [1:0] mv, mk, mm, mf;
  logic mkp, mmp, mrst;
  int mhold, mcnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mv <= 2'b11; mk <= 2'b00; mm <= 2'b00; mf <= 2'b00;
      mkp <= 1'b0; mmp <= 1'b0; mrst <= 1'b1; mhold <= 0; mcnt <= 0;
    end else begin
      bit clr, exp_now;
      clr = (mk[1] != mkp) || (mm[1] != mmp) || (mm[1] && mf[1] && mcnt == svc_of());
      exp_now = !mrst && !wd_off && !clr && (mcnt == lim_of(mm[1]) - 1);
      mv <= {mv[0], vlow}; mk <= {mk[0], kick}; mm <= {mm[0], ext_mode}; mf <= {mf[0], kick_float};
      mkp <= mk[1]; mmp <= mm[1];
      if (mv[1]) begin mrst <= 1'b1; mhold <= 0; end
      else if (mrst) begin
        if (mhold == HOLD - 1) begin mrst <= 1'b0; mhold <= 0; end
        else mhold <= mhold + 1;
      end else if (exp_now) begin mrst <= 1'b1; mhold <= 0; end
      if (mrst || wd_off || clr || mcnt == lim_of(mm[1]) - 1) mcnt <= 0;
      else mcnt <= mcnt + 1;
    end
  end

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string tag = "R11";
  bit done = 1'b0;

  task automatic chk(input string req, input logic act, input logic exp_v, input string what);
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b (cycle %0d)", req, what, act, exp_v, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      cyc++;
      chk(tag, rst_lo, !mrst, "sys_rst active-low");
      chk("R12", rst_hi, mrst, "sys_rst active-high");
      chk("R10", act_lo, !wd_off && !(mm[1] && mf[1]), "wd_active");
      chk("R12", act_hi, act_lo, "wd_active match");
      if (cyc > 190000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    // R11: reset state while rst_n is low
    wait_cyc(4);
    @(negedge clk) rst_n = 1'b1;
    tag = "R2";  wait_cyc(HOLD + 6);
    // R3 R4 R8 R7: repeated normal-mode expiry
    tag = "R8";  wait_cyc(3 * (HOLD + BASE) + 5);
    // R5: kicks with varied spacing, both edges
    tag = "R5";
    for (int i = 0; i < 60; i++) begin
      kick = ~kick;
      wait_cyc($urandom_range(1, 36));
    end
    for (int i = 0; i < 40; i++) begin
      kick = ~kick;
      wait_cyc($urandom_range(20, 48));
    end
    // R1 R2: supply dips of assorted length
    tag = "R1";
    for (int i = 0; i < 12; i++) begin
      vlow = 1'b1; wait_cyc($urandom_range(1, 30));
      vlow = 1'b0; wait_cyc($urandom_range(1, HOLD + 20));
    end
    wait_cyc(HOLD + 5);
    // R6: mode flip mid-count postpones expiry
    tag = "R6";
    wait_cyc(BASE - 10);
    ext_mode = 1'b1; wait_cyc(25);
    ext_mode = 1'b0; wait_cyc(BASE + HOLD + 10);
    // R7: extended timeout runs to expiry once
    tag = "R7";
    ext_mode = 1'b1;
    wait_cyc(BASE * MULT + HOLD + 50);
    // R9: floating kick self-serviced in extended mode
    tag = "R9";
    kick_float = 1'b1;
    wait_cyc(BASE * MULT * 2 + 500);
    // R9: no self-service in normal mode
    ext_mode = 1'b0;
    wait_cyc(3 * (BASE + HOLD));
    kick_float = 1'b0;
    // R10: watchdog strapped off, supply path still works
    tag = "R10";
    wd_off = 1'b1;
    wait_cyc(10 * BASE);
    vlow = 1'b1; wait_cyc(5); vlow = 1'b0;
    wait_cyc(5 * BASE);
    wd_off = 1'b0;
    // mixed random phase
    tag = "R4";
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(0, 99) < 4) kick = ~kick;
      if ($urandom_range(0, 499) == 0) vlow = ~vlow;
      if ($urandom_range(0, 799) == 0) ext_mode = ~ext_mode;
      if ($urandom_range(0, 599) == 0) kick_float = ~kick_float;
      if ($urandom_range(0, 2999) == 0) wd_off = ~wd_off;
      wait_cyc(1);
    end
    vlow = 1'b0;
    wait_cyc(HOLD + 5);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule